// File: doc/BRIEF.md
# Dual-Preset Event/Delay Counter

This block is a 16-bit counter that either counts events or measures a delay. It has two preset registers. The event preset holds a count N. The delay preset holds a count D. A host fills each preset one byte at a time over a narrow write-only register bus.

A sequencer picks which preset starts the counter by pulsing one of two load strobes. A count-enable input qualifies each counting clock. When the programmed number of qualified clocks has passed since the load, the block emits a one-cycle carry pulse. It then stays idle until the next load.

Internally the load writes the two's complement of the wanted span into the counter. The counter then only has to roll over at all-ones, so a single increment and a single terminal test serve both modes.

Top module: `evdly_counter`

## Requirements
- R1: After reset the event preset reads as 1, the delay preset as 0, the counter is idle and `carry_o` is low. A load issued before any write therefore produces no carry.
- R2: A byte write with `reg_wr_en` high lands by address: 0x41 is the low byte of the event preset, 0x42 its high byte, 0x43 the low byte of the delay preset and 0x44 its high byte. A write to any other address changes neither preset.
- R3: A `load_evt` pulse with an event preset N of 2 or more makes `carry_o` high exactly after the (N-1)-th qualified clock edge following the load edge. With `cnt_en` held high, that is N-1 cycles after the load.
- R4: A `load_dly` pulse with a delay preset D of 1 or more makes `carry_o` high exactly after the D-th qualified clock edge following the load edge.
- R5: Loading an event preset of 0 or 1, or a delay preset of 0, leaves the counter idle, and no carry follows.
- R6: A clock edge with `cnt_en` low does not advance the count, so every disabled cycle delays the carry by one cycle.
- R7: `carry_o` is high for one cycle only. After it, the counter stays stopped and raises no further carry until a new load.
- R8: A load strobe overrides counting in the same cycle. A load during a run restarts the span from the full preset value.
- R9: When `load_evt` and `load_dly` are high together, the event preset is used.
- R10: Writing a preset while a run is in progress does not change that run's span. The new value is used from the next load onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Byte write strobe for the preset registers |
| reg_addr | input | 8 | Byte write address |
| reg_wdata | input | 8 | Byte write data |
| load_evt | input | 1 | Copy the event preset into the counter |
| load_dly | input | 1 | Copy the delay preset into the counter |
| cnt_en | input | 1 | Qualifies a counting clock edge |
| carry_o | output | 1 | One-cycle pulse at terminal count |

## Verification
The carry is a register. It is therefore seen in the cycle after the clock edge that completes the span, where the load edge counts as edge zero. With `cnt_en` steady high, that places it N-1 (event) or D (delay) cycles after the load.

The bench drives inputs at falling edges and samples `carry_o` at the next falling edge. It counts qualified edges itself, so in every cycle of a run it knows whether the carry is due, and it compares on each cycle rather than only at the expected end. Each run continues a few cycles past the carry to show that nothing further follows. A preset write or a load takes effect at the edge that samples it, and the bench updates its own model at that same point.

// File: rtl/evdly_pkg.sv
// Package: shared constants and types for the event/delay counter.
// Assumes byte-wide register access with the presets at fixed offsets.
package evdly_pkg;

    // Which preset feeds the counter on a load.
    typedef enum logic {
        PSEL_EVENT = 1'b0,
        PSEL_DELAY = 1'b1
    } preset_sel_e;

    // Base byte offsets of the two presets (low byte first).
    localparam logic [7:0] EVT_BASE_DEF = 8'h41;
    localparam logic [7:0] DLY_BASE_DEF = 8'h43;

endpackage

// File: rtl/evdly_preset_regs.sv
// Module: evdly_preset_regs
// Holds the event and delay presets, written one byte per clock by a host.
// Assumes CNT_W is a multiple of BYTE_W and that the delay preset bytes
// directly follow the event preset bytes in the address space.
module evdly_preset_regs #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] EVT_BASE = 8'h41,
    parameter logic [ADDR_W-1:0] DLY_BASE = 8'h43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  evt_preset,
    output logic [CNT_W-1:0]  dly_preset
);

    localparam int NBYTES = CNT_W / BYTE_W;
    localparam logic [CNT_W-1:0] EVT_RST = CNT_W'(1);
    localparam logic [CNT_W-1:0] DLY_RST = '0;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(int'(DLY_BASE) + NBYTES);

    logic [CNT_W-1:0] evt_q;
    logic [CNT_W-1:0] dly_q;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam logic [ADDR_W-1:0] EVT_ADDR = ADDR_W'(int'(EVT_BASE) + b);
        localparam logic [ADDR_W-1:0] DLY_ADDR = ADDR_W'(int'(DLY_BASE) + b);

        // Event preset byte b: reset value or host write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt_q[b*BYTE_W +: BYTE_W] <= EVT_RST[b*BYTE_W +: BYTE_W];
            end else if (wr_en && wr_addr == EVT_ADDR) begin
                evt_q[b*BYTE_W +: BYTE_W] <= wr_data;
            end
        end

        // Delay preset byte b: reset value or host write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_q[b*BYTE_W +: BYTE_W] <= DLY_RST[b*BYTE_W +: BYTE_W];
            end else if (wr_en && wr_addr == DLY_ADDR) begin
                dly_q[b*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    assign evt_preset = evt_q;
    assign dly_preset = dly_q;

    // Writes outside the preset window must not disturb either preset.
    assert_ignore_other_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr < EVT_BASE || wr_addr >= TOP_ADDR))
        |=> ($stable(evt_q) && $stable(dly_q)));

endmodule

// File: rtl/evdly_load_calc.sv
// Module: evdly_load_calc
// Picks the preset for a load and turns it into a counter start value.
// The span is N-1 for the event preset and D for the delay preset. The start
// value is the span's two's complement, so the counter reaches all-ones and
// rolls over after exactly 'span' increments. A zero span means "do not run".
module evdly_load_calc
    import evdly_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             load_evt,
    input  logic             load_dly,
    input  logic [CNT_W-1:0] evt_preset,
    input  logic [CNT_W-1:0] dly_preset,
    output logic             load_go,
    output logic             run_ok,
    output logic [CNT_W-1:0] start_val
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    preset_sel_e      sel;
    logic [CNT_W-1:0] span;

    // Event strobe has priority when both strobes are present.
    always_comb begin
        sel = load_evt ? PSEL_EVENT : PSEL_DELAY;
    end

    // Span of the selected preset; event counts N-1, values below 2 give zero.
    always_comb begin
        if (sel == PSEL_EVENT) begin
            span = (evt_preset > ONE) ? (evt_preset - ONE) : '0;
        end else begin
            span = dly_preset;
        end
    end

    // Start value and run qualifier handed to the counter core.
    always_comb begin
        load_go   = load_evt | load_dly;
        run_ok    = (span != '0);
        start_val = '0 - span;
    end

endmodule

// File: rtl/evdly_tally_core.sv
// Module: evdly_tally_core
// Running counter: loads a start value, increments on qualified clocks while
// running, and pulses carry for one cycle on rollover from all-ones.
// Assumes a load and counting never act in the same cycle (load wins).
module evdly_tally_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_go,
    input  logic             run_ok,
    input  logic [CNT_W-1:0] start_val,
    input  logic             cnt_en,
    output logic             carry
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             carry_q;

    // Counter, run flag and carry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            carry_q <= 1'b0;
            if (load_go) begin
                cnt_q <= start_val;
                run_q <= run_ok;
            end else if (run_q && cnt_en) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q == '1) begin
                    run_q   <= 1'b0;
                    carry_q <= 1'b1;
                end
            end
        end
    end

    assign carry = carry_q;

    // Carry lasts a single cycle.
    assert_carry_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |=> !carry_q);

    // After carry the counter is stopped.
    assert_stop_after_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |-> !run_q);

    // Without enable or load, nothing moves.
    assert_hold_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load_go) |=> ($stable(cnt_q) && !carry_q));

    // A load of a zero span leaves the counter idle.
    assert_no_run_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_go && !run_ok) |=> !run_q);

    // A load cycle never produces a carry.
    assert_load_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> !carry_q);

endmodule

// File: rtl/evdly_counter.sv
// Module: evdly_counter (top)
// Dual-preset event/delay counter: byte-written presets, strobe-selected load,
// count-enable qualified counting, single-cycle carry at terminal count.
// Assumes synchronous active-low reset and a single clock domain.
module evdly_counter
    import evdly_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              load_evt,
    input  logic              load_dly,
    input  logic              cnt_en,
    output logic              carry_o
);

    logic [CNT_W-1:0] evt_preset;
    logic [CNT_W-1:0] dly_preset;
    logic             load_go;
    logic             run_ok;
    logic [CNT_W-1:0] start_val;

    evdly_preset_regs #(
        .CNT_W   (CNT_W),
        .BYTE_W  (BYTE_W),
        .ADDR_W  (ADDR_W),
        .EVT_BASE(ADDR_W'(EVT_BASE_DEF)),
        .DLY_BASE(ADDR_W'(DLY_BASE_DEF))
    ) u_presets (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .evt_preset(evt_preset),
        .dly_preset(dly_preset)
    );

    evdly_load_calc #(
        .CNT_W(CNT_W)
    ) u_calc (
        .load_evt  (load_evt),
        .load_dly  (load_dly),
        .evt_preset(evt_preset),
        .dly_preset(dly_preset),
        .load_go   (load_go),
        .run_ok    (run_ok),
        .start_val (start_val)
    );

    evdly_tally_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_go  (load_go),
        .run_ok   (run_ok),
        .start_val(start_val),
        .cnt_en   (cnt_en),
        .carry    (carry_o)
    );

endmodule

// File: tb/tb_evdly_counter.sv
`timescale 1ns/1ps
module tb_evdly_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       load_evt = 1'b0;
    logic       load_dly = 1'b0;
    logic       cnt_en = 1'b0;
    logic       carry_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench model of the presets.
    int m_n = 1;
    int m_d = 0;

    always #2.5 clk = ~clk;

    evdly_counter dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .load_evt(load_evt), .load_dly(load_dly),
        .cnt_en(cnt_en), .carry_o(carry_o)
    );

    function automatic int span_of(input int mode);
        if (mode == 1) return m_d;
        return (m_n >= 2) ? m_n - 1 : 0;
    endfunction

    function automatic void model_write(input int a, input int d);
        case (a)
            8'h41: m_n = (m_n & 32'hFF00) | d;
            8'h42: m_n = (m_n & 32'h00FF) | (d << 8);
            8'h43: m_d = (m_d & 32'hFF00) | d;
            8'h44: m_d = (m_d & 32'h00FF) | (d << 8);
            default: ;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input int a, input int d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 8'(a); reg_wdata = 8'(d);
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic write_pair(input int base, input int v);
        write_reg(base, v & 8'hFF);
        write_reg(base + 1, (v >> 8) & 8'hFF);
    endtask

    // mode: 0 event, 1 delay, 2 both strobes (event expected).
    task automatic run_case(input int mode, input int ce_pct, input int reload_at,
                            input int wr_at, input string req);
        int  k, q, post, cap, bad_cyc, bad_act, bad_exp;
        bit  done, ok, ce, reld, expc;
        k = span_of(mode == 1 ? 1 : 0);
        cap = k * 12 + 40;
        q = 0; post = 0; done = 0; ok = 1; bad_cyc = -1; bad_act = 0; bad_exp = 0;
        @(negedge clk);
        load_evt = (mode != 1); load_dly = (mode != 0); cnt_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_evt = 1'b0; load_dly = 1'b0;
        if (carry_o !== 1'b0) begin ok = 0; bad_cyc = 0; bad_act = int'(carry_o); end
        for (int c = 0; c < cap; c++) begin
            ce = (($urandom % 100) < ce_pct);
            reld = (c == reload_at);
            cnt_en = ce;
            if (reld) begin load_evt = (mode != 1); load_dly = (mode != 0); end
            if (c == wr_at) begin reg_wr_en = 1'b1; reg_addr = 8'h43; reg_wdata = 8'h77; end
            @(posedge clk);
            if (c == wr_at) model_write(8'h43, 8'h77);
            @(negedge clk);
            load_evt = 1'b0; load_dly = 1'b0; reg_wr_en = 1'b0;
            if (reld) begin q = 0; done = 0; end
            else if (ce && !done) q++;
            expc = (!done && !reld && k != 0 && ce && q == k);
            if (carry_o !== expc && ok) begin
                ok = 0; bad_cyc = c + 1; bad_act = int'(carry_o); bad_exp = int'(expc);
            end
            if (expc) done = 1;
            if (done || k == 0) post++;
            if (post >= 6) break;
        end
        if (k != 0 && !done && ok) begin ok = 0; bad_cyc = cap; bad_act = 0; bad_exp = 1; end
        if (!ok)
            $display("  run span=%0d mismatch at cycle %0d after load (%s, R7 after carry)",
                     k, bad_cyc, req);
        check(ok, req, bad_act, bad_exp);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(carry_o == 1'b0, "R1 reset carry", int'(carry_o), 0);
        run_case(0, 100, -1, -1, "R1 R5 default N no run");
        run_case(1, 100, -1, -1, "R1 R5 default D no run");

        write_pair(8'h41, 16'h000F);
        write_pair(8'h43, 16'h005A);
        run_case(0, 100, -1, -1, "R3 N=0x000F");
        run_case(1, 100, -1, -1, "R4 D=0x005A");
        run_case(0, 50, -1, -1, "R6 R3 gated enable");
        run_case(1, 40, -1, -1, "R6 R4 gated enable");
        run_case(0, 100, 5, -1, "R8 reload mid run");
        run_case(1, 70, 30, -1, "R8 reload delay");
        run_case(2, 100, -1, -1, "R9 both strobes");

        // R10: a preset write during a run keeps the current span.
        run_case(1, 100, -1, 4, "R10 write during run");
        run_case(1, 100, -1, -1, "R10 new value next load");

        // R2: writes outside the window are ignored.
        write_reg(8'h40, 8'h03);
        write_reg(8'h45, 8'h02);
        write_reg(8'h00, 8'hFF);
        run_case(0, 100, -1, -1, "R2 N unchanged");
        run_case(1, 100, -1, -1, "R2 D unchanged");

        // R5 / R3 boundaries.
        write_pair(8'h41, 16'h0000);
        run_case(0, 100, -1, -1, "R5 N=0");
        write_pair(8'h41, 16'h0002);
        run_case(0, 100, -1, -1, "R3 N=2");
        write_pair(8'h43, 16'h0001);
        run_case(1, 100, -1, -1, "R4 D=1");
        write_pair(8'h41, 16'h0101);
        run_case(0, 100, -1, -1, "R2 R3 high byte");

        for (int i = 0; i < 10; i++) begin
            write_pair(8'h41, $urandom % 300);
            write_pair(8'h43, $urandom % 300);
            run_case(int'($urandom % 3), 50 + int'($urandom % 51), -1, -1, "R3 R4 R6 random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule